// File: doc/BRIEF.md
# CompactFlash Controller Host Register Port

This block is the device side of a small storage controller's microprocessor port. A host on an 8-bit or 16-bit bus reaches a bank of 16-bit registers. Through them it sets the bus width, reads status, error and version words, loads a 28-bit logical block address, writes commands with a sector count, and drives a control word. Data moves through a window at the top half of the address space. A small internal sector RAM stands in for the card. Every 512-byte sector passes through that window in 32-byte chunks, so each sector needs 16 chunks.

Before issuing commands the host must ask for the port through a lock request bit in the control word. The grant appears in status a fixed number of cycles later. After a read or identify command the port reports busy for a programmable time. It then raises buffer-ready once per chunk. A write command follows the same pacing in the other direction. A single interrupt line is raised on a rising buffer-ready or a new error, each gated by its own enable, and it is cleared through a control bit.

Top module: `cf_host_port`

## Requirements
- R1: Bus width mode is 8-bit after reset. A write whose low byte has bit 0 set to the mode register (byte offset 0x00) selects 16-bit mode, and a low byte of 0x00 selects 8-bit mode. Reading it back gives 0x0101 in 16-bit mode and 0x00 in 8-bit mode. In 8-bit mode a 16-bit register is accessed as two byte addresses, low byte at the even address.
- R2: The version register (offset 0x16) returns the VERSION parameter, which can never be 0x0000 or 0xFFFF.
- R3: The block address register (offsets 0x10 low half, 0x12 high half) stores 28 bits, and bits 31:28 always read as zero.
- R4: Status bit 1 (lock granted) rises exactly LOCK_DELAY cycles after control bit 1 (lock request, control at offset 0x18) is set. It falls one cycle after the request is cleared.
- R5: A command written to bits 11:8 of offset 0x14 (low byte = sector count) is ignored unless the lock is granted. Other than abort and reset, a command is also ignored unless the port is idle. Status bit 8 (ready for command) reports lock granted and idle.
- R6: After an accepted read (3), write (4) or identify (2) command, status bit 17 (busy) is high for BUSY_CYCLES cycles. Then status bit 5 (buffer ready) rises.
- R7: Buffer ready falls right after 32 bytes of the window are consumed. It rises again one cycle later until count x 16 chunks are done, and then the port returns to idle.
- R8: Data written through the window is stored at the addressed sectors and reads back unchanged. In 8-bit mode bytes are taken low byte first, and in 16-bit mode one halfword per access.
- R9: The identify command returns one sector whose halfword k is {k[7:0], ~k[7:0]}.
- R10: A read or write whose block address plus count exceeds NUM_SECTORS sets error bit 0 (error register at 0x08). An unknown command code sets error bit 1. Either error sets status bit 3, and a later accepted command clears the error.
- R11: The interrupt rises on a rising buffer ready when control bit 8 is set, or on a new error when control bit 9 is set. It never rises with the enable clear, and it is cleared while control bit 11 is set.
- R12: Abort (6) and reset (1) end any transfer at once, drop buffer ready and busy, and clear the error register.
- R13: Window accesses while buffer ready is low neither move data nor advance the transfer position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data, low byte only in 8-bit mode |
| bus_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench times the lock grant and the end of busy to the exact cycle. A design that counts one edge too many or too few is reported there. It checks that buffer ready drops after the sixteenth halfword or the thirty-second byte of every chunk, and that it comes back for the next chunk across a sector boundary. An off-by-one chunk counter would stall the transfer or run past the end. Narrow-mode transfers are cross-read in wide mode, which catches swapped byte lanes. The bench also reads the window while the port is still busy and then confirms the first real word. A design that advanced its position on those early reads would return the wrong data. Errors raised with their enable clear, a cleared interrupt that re-fires with no new cause, and an abort that leaves buffer ready set are all checked.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} eng_state_t;

   localparam logic [3:0] OP_RESET = 4'd1;
   localparam logic [3:0] OP_IDENT = 4'd2;
   localparam logic [3:0] OP_READ  = 4'd3;
   localparam logic [3:0] OP_WRITE = 4'd4;
   localparam logic [3:0] OP_ABORT = 4'd6;

   // halfword indices (byte address bits 6:1)
   localparam logic [5:0] HW_MODE    = 6'd0;
   localparam logic [5:0] HW_STAT_LO = 6'd2;
   localparam logic [5:0] HW_STAT_HI = 6'd3;
   localparam logic [5:0] HW_ERR_LO  = 6'd4;
   localparam logic [5:0] HW_LBA_LO  = 6'd8;
   localparam logic [5:0] HW_LBA_HI  = 6'd9;
   localparam logic [5:0] HW_CMD     = 6'd10;
   localparam logic [5:0] HW_VER     = 6'd11;
   localparam logic [5:0] HW_CTL_LO  = 6'd12;

   localparam int SB_LOCK   = 1;
   localparam int SB_FAULT  = 3;
   localparam int SB_BUFRDY = 5;
   localparam int SB_CMDRDY = 8;
   localparam int SB_BUSY   = 17;

   localparam int CB_LOCKREQ = 1;
   localparam int CB_BUFIE   = 8;
   localparam int CB_ERRIE   = 9;
   localparam int CB_IRQCLR  = 11;
endpackage

// File: rtl/cfp_lock.sv
module cfp_lock #(
   parameter int LOCK_DELAY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic held
);
   localparam int CW = $clog2(LOCK_DELAY + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         held <= 1'b0;
      end else if (!req) begin
         cnt  <= '0;
         held <= 1'b0;
      end else if (!held) begin
         if (cnt == CW'(LOCK_DELAY - 1)) held <= 1'b1;
         cnt <= cnt + 1'b1;
      end
   end

   // R4: grant falls right after request drops
   a_r4_drop_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !held);
   // R4: grant only rises after the request has been standing
   a_r4_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> (req && $past(req)));
endmodule

// File: rtl/cfp_engine.sv
module cfp_engine
   import cfp_pkg::*;
#(
   parameter int NUM_SECTORS = 4,
   parameter int BUSY_CYCLES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wide,
   input  logic        lock_held,
   input  logic        cmd_go,
   input  logic [3:0]  cmd_code,
   input  logic [7:0]  cmd_count,
   input  logic [27:0] lba,
   input  logic        data_rd,
   input  logic        data_wr,
   input  logic [15:0] wdata,
   output logic        busy,
   output logic        bufrdy,
   output logic        idle,
   output logic [1:0]  err,
   output logic [15:0] rdata
);
   localparam int SECW  = $clog2(NUM_SECTORS);
   localparam int BPW   = SECW + 9;
   localparam int WDW   = BPW - 1;
   localparam int DEPTH = NUM_SECTORS * 256;
   localparam int BCW   = $clog2(BUSY_CYCLES + 1);

   eng_state_t     state;
   logic [BCW-1:0] bcnt;
   logic [BPW-1:0] bp, nbp, start_bp;
   logic [7:0]     left;
   logic           dir_wr, is_id;
   logic [7:0]     lo_hold;
   logic [15:0]    mem [DEPTH];
   logic [15:0]    rd_word, id_word;
   logic [WDW-1:0] word_idx;
   logic           access, kill, start, known, range_bad;

   assign word_idx  = bp[BPW-1:1];
   assign id_word   = {bp[8:1], ~bp[8:1]};
   assign rd_word   = is_id ? id_word : mem[word_idx];
   assign rdata     = wide ? rd_word : {8'h00, bp[0] ? rd_word[15:8] : rd_word[7:0]};
   assign nbp       = bp + (wide ? BPW'(2) : BPW'(1));
   assign start_bp  = {lba[SECW-1:0], 9'd0};
   assign access    = (state == ST_XFER) && bufrdy && (dir_wr ? data_wr : data_rd);
   assign kill      = cmd_go && lock_held && (cmd_code == OP_RESET || cmd_code == OP_ABORT);
   assign start     = cmd_go && lock_held && (state == ST_IDLE) && !kill;
   assign known     = (cmd_code == OP_IDENT) || (cmd_code == OP_READ) || (cmd_code == OP_WRITE);
   assign range_bad = ({1'b0, lba} + {21'd0, cmd_count}) > 29'(NUM_SECTORS);
   assign busy      = (state == ST_WAIT);
   assign idle      = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bcnt    <= '0;
         bp      <= '0;
         left    <= '0;
         dir_wr  <= 1'b0;
         is_id   <= 1'b0;
         lo_hold <= '0;
         err     <= '0;
         bufrdy  <= 1'b0;
      end else if (kill) begin
         state  <= ST_IDLE;
         bufrdy <= 1'b0;
         err    <= '0;
      end else if (start) begin
         if (!known) begin
            err <= 2'b10;
         end else if (cmd_code == OP_IDENT) begin
            err    <= '0;
            state  <= ST_WAIT;
            bcnt   <= BCW'(BUSY_CYCLES);
            bp     <= '0;
            left   <= 8'd1;
            is_id  <= 1'b1;
            dir_wr <= 1'b0;
         end else if (cmd_count == 8'd0) begin
            err <= '0;
         end else if (range_bad) begin
            err <= 2'b01;
         end else begin
            err    <= '0;
            state  <= ST_WAIT;
            bcnt   <= BCW'(BUSY_CYCLES);
            bp     <= start_bp;
            left   <= cmd_count;
            is_id  <= 1'b0;
            dir_wr <= (cmd_code == OP_WRITE);
         end
      end else begin
         case (state)
            ST_WAIT: begin
               if (bcnt == BCW'(1)) begin
                  state  <= ST_XFER;
                  bufrdy <= 1'b1;
               end else begin
                  bcnt <= bcnt - 1'b1;
               end
            end
            ST_XFER: begin
               if (!bufrdy) begin
                  bufrdy <= 1'b1;
               end else if (access) begin
                  if (dir_wr && !wide && !bp[0]) lo_hold <= wdata[7:0];
                  bp <= nbp;
                  if (nbp[4:0] == 5'd0) begin
                     bufrdy <= 1'b0;
                     if (nbp[8:0] == 9'd0) begin
                        if (left == 8'd1) begin
                           state <= ST_IDLE;
                           left  <= 8'd0;
                        end else begin
                           left <= left - 1'b1;
                        end
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (access && dir_wr) begin
         if (wide) mem[word_idx] <= wdata;
         else if (bp[0]) mem[word_idx] <= {wdata[7:0], lo_hold};
      end
   end

   // R6: ready follows the busy window
   a_r6_ready_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && bcnt == BCW'(1) && !kill) |=> bufrdy);
   // R7: a finished chunk drops buffer ready
   a_r7_chunk_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (access && nbp[4:0] == 5'd0) |=> !bufrdy);
   // R13: position only moves on a counted access or a new command
   a_r13_position_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!access && !start) |=> $stable(bp));
   // R5: no lock, no start
   a_r5_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && !lock_held && state == ST_IDLE) |=> (state == ST_IDLE && !bufrdy));
endmodule

// File: rtl/cfp_irq.sv
module cfp_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic bufrdy,
   input  logic err_any,
   input  logic en_buf,
   input  logic en_err,
   input  logic clr,
   output logic irq
);
   logic bufrdy_q, err_q, cause;

   assign cause = (en_buf && bufrdy && !bufrdy_q) || (en_err && err_any && !err_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bufrdy_q <= 1'b0;
         err_q    <= 1'b0;
         irq      <= 1'b0;
      end else begin
         bufrdy_q <= bufrdy;
         err_q    <= err_any;
         if (clr) irq <= 1'b0;
         else if (cause) irq <= 1'b1;
      end
   end

   // R11: clearing wins
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !irq);
   // R11: every rise has an enabled cause
   a_r11_enabled_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((en_buf && bufrdy && !bufrdy_q) || (en_err && err_any && !err_q)));
endmodule

// File: rtl/cf_host_port.sv
module cf_host_port
   import cfp_pkg::*;
#(
   parameter int          NUM_SECTORS = 4,
   parameter int          BUSY_CYCLES = 8,
   parameter int          LOCK_DELAY  = 3,
   parameter logic [15:0] VERSION     = 16'h1203
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [6:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        irq
);
   localparam int LBA_W = 28;

   generate
      if (VERSION == 16'h0000 || VERSION == 16'hFFFF) begin : g_bad_version
         $error("VERSION must not be all zeros or all ones");
      end
      if (LOCK_DELAY < 2) begin : g_bad_lock
         $error("LOCK_DELAY must be at least 2");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
      if (NUM_SECTORS < 2 || NUM_SECTORS > 256 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_sectors
         $error("NUM_SECTORS must be a power of two from 2 to 256");
      end
   endgenerate

   logic             wide;
   logic [LBA_W-1:0] lba_q;
   logic [7:0]       cnt_q;
   logic [3:0]       op_q;
   logic [15:0]      ctrl_q;
   logic [5:0]       hw;
   logic             is_data, lo_we, hi_we;
   logic [7:0]       lo_b, hi_b;
   logic             cmd_go;
   logic [7:0]       cmd_count;
   logic             lock_held, busy, bufrdy, idle;
   logic [1:0]       err;
   logic [15:0]      eng_rdata, half;
   logic [31:0]      stat;

   assign hw      = bus_addr[6:1];
   assign is_data = bus_addr[6];
   assign lo_we   = bus_wr && !is_data && (wide || !bus_addr[0]);
   assign hi_we   = bus_wr && !is_data && (wide || bus_addr[0]);
   assign lo_b    = bus_wdata[7:0];
   assign hi_b    = wide ? bus_wdata[15:8] : bus_wdata[7:0];
   assign cmd_go  = hi_we && (hw == HW_CMD);
   assign cmd_count = wide ? bus_wdata[7:0] : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide   <= 1'b0;
         lba_q  <= '0;
         cnt_q  <= '0;
         op_q   <= '0;
         ctrl_q <= '0;
      end else begin
         if (lo_we) begin
            case (hw)
               HW_MODE:   wide          <= lo_b[0];
               HW_LBA_LO: lba_q[7:0]    <= lo_b;
               HW_LBA_HI: lba_q[23:16]  <= lo_b;
               HW_CMD:    cnt_q         <= lo_b;
               HW_CTL_LO: ctrl_q[7:0]   <= lo_b;
               default: ;
            endcase
         end
         if (hi_we) begin
            case (hw)
               HW_LBA_LO: lba_q[15:8]   <= hi_b;
               HW_LBA_HI: lba_q[27:24]  <= hi_b[3:0];
               HW_CMD:    op_q          <= hi_b[3:0];
               HW_CTL_LO: ctrl_q[15:8]  <= hi_b;
               default: ;
            endcase
         end
      end
   end

   cfp_lock #(.LOCK_DELAY(LOCK_DELAY)) u_lock (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (ctrl_q[CB_LOCKREQ]),
      .held (lock_held)
   );

   cfp_engine #(.NUM_SECTORS(NUM_SECTORS), .BUSY_CYCLES(BUSY_CYCLES)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide     (wide),
      .lock_held(lock_held),
      .cmd_go   (cmd_go),
      .cmd_code (hi_b[3:0]),
      .cmd_count(cmd_count),
      .lba      (lba_q),
      .data_rd  (bus_rd && is_data),
      .data_wr  (bus_wr && is_data),
      .wdata    (bus_wdata),
      .busy     (busy),
      .bufrdy   (bufrdy),
      .idle     (idle),
      .err      (err),
      .rdata    (eng_rdata)
   );

   cfp_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .bufrdy (bufrdy),
      .err_any(|err),
      .en_buf (ctrl_q[CB_BUFIE]),
      .en_err (ctrl_q[CB_ERRIE]),
      .clr    (ctrl_q[CB_IRQCLR]),
      .irq    (irq)
   );

   always_comb begin
      stat = '0;
      stat[SB_LOCK]   = lock_held;
      stat[SB_FAULT]  = |err;
      stat[SB_BUFRDY] = bufrdy;
      stat[SB_CMDRDY] = lock_held && idle;
      stat[SB_BUSY]   = busy;
   end

   always_comb begin
      case (hw)
         HW_MODE:    half = wide ? 16'h0101 : 16'h0000;
         HW_STAT_LO: half = stat[15:0];
         HW_STAT_HI: half = stat[31:16];
         HW_ERR_LO:  half = {14'd0, err};
         HW_LBA_LO:  half = lba_q[15:0];
         HW_LBA_HI:  half = {4'd0, lba_q[27:16]};
         HW_CMD:     half = {4'd0, op_q, cnt_q};
         HW_VER:     half = VERSION;
         HW_CTL_LO:  half = ctrl_q;
         default:    half = 16'h0000;
      endcase
   end

   assign bus_rdata = is_data ? eng_rdata
                    : (wide ? half : {8'h00, bus_addr[0] ? half[15:8] : half[7:0]});
endmodule

// File: tb/cf_host_port_test.sv
`timescale 1ns/100ps
module cf_host_port_test;
   localparam int          NS   = 4;
   localparam int          BUSY = 8;
   localparam int          LOCKD = 3;
   localparam logic [15:0] VER  = 16'h1203;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit wide_m = 1'b0;

   always #2.5 clk = ~clk;

   cf_host_port #(.NUM_SECTORS(NS), .BUSY_CYCLES(BUSY), .LOCK_DELAY(LOCKD), .VERSION(VER)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   function automatic logic [15:0] pw(input int k);
      return 16'(k * 7 + 16'h0100);
   endfunction

   function automatic logic [7:0] pb(input int k);
      return 8'(k) ^ 8'h5A;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_w(input logic [6:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_r(input logic [6:0] a, output logic [15:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [6:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic reg_w(input logic [6:0] a, input logic [15:0] d);
      if (wide_m) bus_w(a, d);
      else begin
         bus_w(a, {8'h00, d[7:0]});
         bus_w(a + 7'd1, {8'h00, d[15:8]});
      end
   endtask

   task automatic reg_r(input logic [6:0] a, output logic [15:0] d);
      logic [15:0] lo, hi;
      if (wide_m) bus_r(a, d);
      else begin
         bus_r(a, lo);
         bus_r(a + 7'd1, hi);
         d = {hi[7:0], lo[7:0]};
      end
   endtask

   task automatic wait_buf(input string req, output bit ok);
      logic [15:0] s;
      ok = 1'b0;
      for (int i = 0; i < 200; i++) begin
         peek(7'h04, s);
         if (s[5]) begin ok = 1'b1; break; end
         @(negedge clk);
      end
      if (!ok) chk(req, 32'h0, 32'h1);
   endtask

   task automatic t_reset;
      logic [15:0] d;
      peek(7'h04, d); chk("R5 reset status low", {16'h0, d}, 32'h0);
      peek(7'h06, d); chk("R6 reset status high", {16'h0, d}, 32'h0);
      chk("R11 reset irq", {31'h0, irq}, 32'h0);
      reg_r(7'h16, d); chk("R2 version", {16'h0, d}, {16'h0, VER});
      peek(7'h00, d); chk("R1 reset mode narrow", {16'h0, d}, 32'h0);
   endtask

   task automatic t_mode;
      logic [15:0] d;
      bus_w(7'h00, 16'h0001); wide_m = 1'b1;
      reg_r(7'h00, d); chk("R1 wide readback", {16'h0, d}, 32'h0101);
      reg_w(7'h00, 16'h0000); wide_m = 1'b0;
      reg_r(7'h00, d); chk("R1 narrow readback", {16'h0, d}, 32'h0);
      bus_w(7'h00, 16'h0001); wide_m = 1'b1;
   endtask

   task automatic t_lba;
      logic [15:0] d;
      reg_w(7'h10, 16'hFFFF); reg_w(7'h12, 16'hFFFF);
      reg_r(7'h12, d); chk("R3 lba upper bits", {16'h0, d}, 32'h0FFF);
      reg_r(7'h10, d); chk("R3 lba lower half", {16'h0, d}, 32'hFFFF);
   endtask

   task automatic t_nolock;
      logic [15:0] d;
      reg_w(7'h10, 16'h0001); reg_w(7'h12, 16'h0000);
      reg_w(7'h14, 16'h0301);
      peek(7'h06, d); chk("R5 no busy without lock", {16'h0, d}, 32'h0);
      repeat (BUSY + 4) @(negedge clk);
      peek(7'h04, d); chk("R5 no buffer without lock", {16'h0, d}, 32'h0);
   endtask

   task automatic t_lock;
      logic [15:0] d;
      reg_w(7'h18, 16'h0002);
      peek(7'h04, d); chk("R4 not granted at once", {31'h0, d[1]}, 32'h0);
      repeat (LOCKD - 1) @(negedge clk);
      peek(7'h04, d); chk("R4 not granted early", {31'h0, d[1]}, 32'h0);
      @(negedge clk);
      peek(7'h04, d); chk("R4 granted on time", {16'h0, d}, 32'h0102);
      reg_w(7'h18, 16'h0000);
      @(negedge clk);
      peek(7'h04, d); chk("R4 released", {31'h0, d[1]}, 32'h0);
      reg_w(7'h18, 16'h0002);
      repeat (LOCKD + 1) @(negedge clk);
   endtask

   task automatic t_write_multi;
      logic [15:0] d;
      bit ok;
      reg_w(7'h10, 16'h0001);
      reg_w(7'h14, 16'h0402);
      peek(7'h06, d); chk("R6 busy after write command", {16'h0, d}, 32'h0002);
      for (int c = 0; c < 32; c++) begin
         wait_buf("R7 write chunk ready", ok);
         if (!ok) return;
         for (int w = 0; w < 16; w++) bus_w(7'h40, pw(c * 16 + w));
         peek(7'h04, d); chk("R7 ready drops after chunk", {31'h0, d[5]}, 32'h0);
      end
      @(negedge clk);
      peek(7'h04, d); chk("R7 idle after last chunk", {16'h0, d}, 32'h0102);
   endtask

   task automatic t_read_wide;
      logic [15:0] d;
      bit ok;
      reg_w(7'h10, 16'h0001);
      reg_w(7'h14, 16'h0302);
      peek(7'h06, d); chk("R6 busy after read command", {31'h0, d[1]}, 32'h1);
      repeat (BUSY - 1) @(negedge clk);
      peek(7'h04, d); chk("R6 no buffer during busy", {31'h0, d[5]}, 32'h0);
      @(negedge clk);
      peek(7'h04, d); chk("R6 buffer ready after busy", {31'h0, d[5]}, 32'h1);
      peek(7'h06, d); chk("R6 busy ended", {16'h0, d}, 32'h0);
      for (int c = 0; c < 32; c++) begin
         wait_buf("R7 read chunk ready", ok);
         if (!ok) return;
         for (int w = 0; w < 16; w++) begin
            bus_r(7'h40, d);
            chk("R8 wide read data", {16'h0, d}, {16'h0, pw(c * 16 + w)});
         end
      end
   endtask

   task automatic t_narrow;
      logic [15:0] d, w;
      bit ok;
      reg_w(7'h00, 16'h0000); wide_m = 1'b0;
      reg_w(7'h10, 16'h0002);
      reg_w(7'h14, 16'h0301);
      for (int c = 0; c < 16; c++) begin
         wait_buf("R7 narrow read chunk", ok);
         if (!ok) return;
         for (int b = 0; b < 32; b++) begin
            bus_r(7'h40, d);
            w = pw(256 + (c * 32 + b) / 2);
            chk("R8 narrow read byte", {16'h0, d}, {24'h0, (b % 2) ? w[15:8] : w[7:0]});
         end
      end
      reg_w(7'h10, 16'h0003);
      reg_w(7'h14, 16'h0401);
      for (int c = 0; c < 16; c++) begin
         wait_buf("R7 narrow write chunk", ok);
         if (!ok) return;
         for (int b = 0; b < 32; b++) bus_w(7'h40, {8'h00, pb(c * 32 + b)});
      end
      bus_w(7'h00, 16'h0001); wide_m = 1'b1;
      reg_w(7'h10, 16'h0003);
      reg_w(7'h14, 16'h0301);
      for (int c = 0; c < 16; c++) begin
         wait_buf("R8 cross read chunk", ok);
         if (!ok) return;
         for (int j = 0; j < 16; j++) begin
            bus_r(7'h40, d);
            chk("R8 narrow bytes low first", {16'h0, d},
                {16'h0, pb(2 * (c * 16 + j) + 1), pb(2 * (c * 16 + j))});
         end
      end
   endtask

   task automatic t_ident;
      logic [15:0] d;
      bit ok;
      reg_w(7'h14, 16'h0200);
      for (int c = 0; c < 16; c++) begin
         wait_buf("R9 identify chunk", ok);
         if (!ok) return;
         for (int j = 0; j < 16; j++) begin
            bus_r(7'h40, d);
            chk("R9 identify word", {16'h0, d},
                {16'h0, 8'(c * 16 + j), ~8'(c * 16 + j)});
         end
      end
   endtask

   task automatic t_err;
      logic [15:0] d;
      reg_w(7'h10, 16'h0003);
      reg_w(7'h14, 16'h0302);
      reg_r(7'h08, d); chk("R10 range error bit", {16'h0, d}, 32'h1);
      peek(7'h04, d); chk("R10 fault in status", {16'h0, d}, 32'h010A);
      reg_w(7'h14, 16'h0100);
      reg_r(7'h08, d); chk("R12 reset clears error", {16'h0, d}, 32'h0);
      reg_w(7'h14, 16'h0500);
      reg_r(7'h08, d); chk("R10 unknown command bit", {16'h0, d}, 32'h2);
      reg_w(7'h14, 16'h0600);
      reg_r(7'h08, d); chk("R12 abort clears error", {16'h0, d}, 32'h0);
   endtask

   task automatic t_irq;
      logic [15:0] d;
      bit ok;
      reg_w(7'h14, 16'h0500);
      repeat (3) @(negedge clk);
      chk("R11 no irq with enables clear", {31'h0, irq}, 32'h0);
      reg_w(7'h14, 16'h0100);
      reg_w(7'h18, 16'h0202);
      reg_w(7'h14, 16'h0500);
      @(negedge clk);
      chk("R11 error irq", {31'h0, irq}, 32'h1);
      reg_w(7'h18, 16'h0A02);
      @(negedge clk);
      chk("R11 irq cleared", {31'h0, irq}, 32'h0);
      reg_w(7'h18, 16'h0202);
      repeat (3) @(negedge clk);
      chk("R11 no refire without new error", {31'h0, irq}, 32'h0);
      reg_w(7'h14, 16'h0100);
      reg_w(7'h18, 16'h0102);
      reg_w(7'h10, 16'h0001);
      reg_w(7'h14, 16'h0301);
      for (int i = 0; i < 3; i++) bus_r(7'h40, d);
      chk("R11 no buffer irq during busy", {31'h0, irq}, 32'h0);
      wait_buf("R13 ready after early reads", ok);
      if (!ok) return;
      @(negedge clk);
      chk("R11 buffer irq", {31'h0, irq}, 32'h1);
      bus_r(7'h40, d); chk("R13 early reads ignored", {16'h0, d}, {16'h0, pw(0)});
      for (int i = 1; i < 5; i++) bus_r(7'h40, d);
      reg_w(7'h14, 16'h0600);
      peek(7'h04, d); chk("R12 abort ends transfer", {16'h0, d}, 32'h0102);
      peek(7'h06, d); chk("R12 abort not busy", {16'h0, d}, 32'h0);
      reg_w(7'h18, 16'h0802);
      reg_w(7'h18, 16'h0002);
   endtask

   initial begin
      #(100000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode();
      t_lba();
      t_nolock();
      t_lock();
      t_write_multi();
      t_read_wide();
      t_narrow();
      t_ident();
      t_err();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule